// File: doc/BRIEF.md
# Auxiliary Control Register Access Router

This block takes one system-register access at a time and decides where it goes. The target is a 64-bit auxiliary control register, held in two copies: one for the level-1 context and one for the level-2 host context. Each request carries the five encoding fields, a read/write flag, write data and the current privilege level. It also carries the hypervisor controls: level-2 enable, trap-auxiliary bit, host mode, the three nested-virtualization bits, and the fine-grained trap enables.

The block settles each request into exactly one of five outcomes:

- undefined;
- trap to level 2, with exception class 0x18;
- access to the level-1 copy;
- access to the level-2 copy;
- redirect to a memory slot at offset 0x118.

Register writes can be partly protected by a per-copy preserve mask. Redirected accesses leave through a strobe/acknowledge memory port.

Build options are parameters:

- `ALT_ACCESSOR` selects the alternate accessor behaviour, which adds the cross-level alias encoding.
- `MASK_FEATURE` selects the write-preserve feature, which adds the masked alias encoding.
- `FINE_TRAP` selects fine-grained trapping.

A request is taken only while `req_ready` is high. A response appears as a one-cycle `rsp_valid` pulse.

Top module: `sysreg_aux_router`

## Requirements
- R1: After reset both register copies read as zero, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R2: The encodings use op0=3 and CRn=1 throughout. The primary encoding is op1=0, CRm=0, op2=1. The cross-level alias is op1=5, CRm=0, op2=1, and exists only with `ALT_ACCESSOR`. The masked alias is op1=0, CRm=4, op2=5, and exists only with `MASK_FEATURE`. Any other encoding, and any access at level 0, is undefined.
- R3: A register, trap or undefined outcome is reported in the cycle after acceptance. `rsp_status` is one-hot with these bits: bit0 undefined, bit1 trap, bit2 level-1 copy, bit3 level-2 copy, bit4 memory. `rsp_ec` is 0x18 with a trap and 0 otherwise.
- R4: At level 1, the primary or masked alias traps when `el2_en` and `trap_aux` are both 1.
- R5: At level 1, with `FINE_TRAP` and `el2_en`, the masked alias also traps when either of these holds:
  - `el3_present` is 1 and `fgt_el3_en` is 0;
  - the fine-grained enable for the access direction is 0 (`fgt_rd_en` for reads, `fgt_wr_en` for writes).
- R6: At level 1, if no trap applies, the primary or masked alias is redirected to memory when `nv` matches 1x1 and either `ALT_ACCESSOR` is 0 or `nv` is 111. Otherwise it reaches the level-1 copy.
- R7: At level 1, the cross-level alias behaves as follows:
  - `nv` of 101 redirects to memory;
  - any other `nv` with bit0 set traps;
  - everything else is undefined.
- R8: At levels 2 and 3, the cross-level alias reaches the level-1 copy when `host_mode` is 1, and is undefined otherwise.
- R9: At level 2, the primary and masked alias reach the level-2 copy when `ALT_ACCESSOR` and `host_mode` are both 1, and the level-1 copy otherwise. At level 3 they always reach the level-1 copy.
- R10: With `MASK_FEATURE`, two kinds of write store (wdata & ~mask) | (old & mask): level-1 writes through the primary or masked alias (using `mask_l1`), and level-2 host writes to the level-2 copy (using `mask_l2`). All other register writes store wdata whole.
- R11: A register read returns the addressed copy's contents in `rsp_rdata`. A write response carries `rsp_rdata` of 0.
- R12: A memory redirect works as follows:
  - `mem_req` rises in the cycle after acceptance, with `mem_addr` 0x118, `mem_write` and `mem_wdata` taken from the request;
  - it holds until `mem_ack`;
  - the memory status is reported in the cycle after the ack;
  - a read returns `mem_rdata`, and a write returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 write, 0 read |
| req_op0 | input | 2 | Encoding op0 |
| req_op1 | input | 3 | Encoding op1 |
| req_crn | input | 4 | Encoding CRn |
| req_crm | input | 4 | Encoding CRm |
| req_op2 | input | 3 | Encoding op2 |
| req_el | input | 2 | Current privilege level |
| req_wdata | input | DW | Write data |
| el2_en | input | 1 | Level 2 enabled in this state |
| trap_aux | input | 1 | Trap auxiliary control accesses to level 2 |
| host_mode | input | 1 | Level 2 runs as host |
| nv | input | 3 | Nested-virtualization bits, {bit2,bit1,bit0} |
| el3_present | input | 1 | Level 3 exists |
| fgt_el3_en | input | 1 | Level-3 enable of fine-grained traps |
| fgt_rd_en | input | 1 | Fine-grained read enable for the masked alias |
| fgt_wr_en | input | 1 | Fine-grained write enable for the masked alias |
| mask_l1 | input | DW | Preserve mask of the level-1 copy |
| mask_l2 | input | DW | Preserve mask of the level-2 copy |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 5 | One-hot outcome |
| rsp_ec | output | ECW | Trap class |
| rsp_rdata | output | DW | Read data |
| mem_req | output | 1 | Memory request strobe |
| mem_write | output | 1 | Memory write flag |
| mem_addr | output | AW | Memory offset |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | DW | Memory read data |

## Verification
A wrong routing decision shows at the next response as a different one-hot status bit, one cycle after acceptance. A corrupted register copy stays hidden until the next read of that copy. That read returns a value the reference model does not predict, so each write is followed within the sweep by reads under many control settings. A wrong mask merge shows the same way, as bits that changed or failed to change. A fault in the memory handshake shows as a stuck `mem_req` or a missing response, caught within a few cycles of the acknowledge. Two builds run side by side, one with all options and one with none, so that every option-dependent branch gets exercised.

// File: rtl/sysreg_aux_router.sv
module sysreg_aux_router #(
  parameter bit ALT_ACCESSOR = 1'b1,
  parameter bit MASK_FEATURE = 1'b1,
  parameter bit FINE_TRAP    = 1'b1,
  parameter int DW  = 64,
  parameter int AW  = 12,
  parameter int ECW = 6,
  parameter logic [AW-1:0]  SLOT_OFS   = 12'h118,
  parameter logic [ECW-1:0] TRAP_CLASS = 6'h18
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [1:0]     req_op0,
  input  logic [2:0]     req_op1,
  input  logic [3:0]     req_crn,
  input  logic [3:0]     req_crm,
  input  logic [2:0]     req_op2,
  input  logic [1:0]     req_el,
  input  logic [DW-1:0]  req_wdata,
  input  logic           el2_en,
  input  logic           trap_aux,
  input  logic           host_mode,
  input  logic [2:0]     nv,
  input  logic           el3_present,
  input  logic           fgt_el3_en,
  input  logic           fgt_rd_en,
  input  logic           fgt_wr_en,
  input  logic [DW-1:0]  mask_l1,
  input  logic [DW-1:0]  mask_l2,
  output logic           rsp_valid,
  output logic [4:0]     rsp_status,
  output logic [ECW-1:0] rsp_ec,
  output logic [DW-1:0]  rsp_rdata,
  output logic           mem_req,
  output logic           mem_write,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata
);
  localparam logic [4:0] O_UNDEF = 5'b00001;
  localparam logic [4:0] O_TRAP  = 5'b00010;
  localparam logic [4:0] O_REG1  = 5'b00100;
  localparam logic [4:0] O_REG2  = 5'b01000;
  localparam logic [4:0] O_MEM   = 5'b10000;

  logic [DW-1:0] reg1, reg2;
  logic          waiting;
  logic [4:0]    outc;
  logic          mask_use;

  wire base   = (req_op0 == 2'd3) && (req_crn == 4'd1);
  wire hit_p  = base && req_op1 == 3'd0 && req_crm == 4'd0 && req_op2 == 3'd1;
  wire hit_x  = ALT_ACCESSOR && base && req_op1 == 3'd5 && req_crm == 4'd0 && req_op2 == 3'd1;
  wire hit_m  = MASK_FEATURE && base && req_op1 == 3'd0 && req_crm == 4'd4 && req_op2 == 3'd5;
  wire fg_hit = FINE_TRAP && el2_en &&
                ((el3_present && !fgt_el3_en) || (req_write ? !fgt_wr_en : !fgt_rd_en));
  wire accept = req_valid && !waiting;

  assign req_ready = !waiting;
  assign mem_addr  = SLOT_OFS;
  assign rsp_ec    = rsp_status[1] ? TRAP_CLASS : '0;

  always_comb begin
    outc     = O_UNDEF;
    mask_use = 1'b0;
    if (req_el == 2'd0 || !(hit_p || hit_x || hit_m)) begin
      outc = O_UNDEF;
    end else if (hit_x) begin
      if (req_el == 2'd1) begin
        if (nv == 3'b101)  outc = O_MEM;
        else if (nv[0])    outc = O_TRAP;
        else               outc = O_UNDEF;
      end else begin
        outc = host_mode ? O_REG1 : O_UNDEF;
      end
    end else begin
      case (req_el)
        2'd1: begin
          if (el2_en && trap_aux)                                outc = O_TRAP;
          else if (hit_m && fg_hit)                              outc = O_TRAP;
          else if (nv[2] && nv[0] && (!ALT_ACCESSOR || nv == 3'b111)) outc = O_MEM;
          else begin
            outc     = O_REG1;
            mask_use = MASK_FEATURE;
          end
        end
        2'd2: begin
          if (ALT_ACCESSOR && host_mode) begin
            outc     = O_REG2;
            mask_use = MASK_FEATURE;
          end else begin
            outc = O_REG1;
          end
        end
        default: outc = O_REG1;
      endcase
    end
  end

  wire [DW-1:0] new1 = mask_use ? ((req_wdata & ~mask_l1) | (reg1 & mask_l1)) : req_wdata;
  wire [DW-1:0] new2 = mask_use ? ((req_wdata & ~mask_l2) | (reg2 & mask_l2)) : req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg1       <= '0;
      reg2       <= '0;
      waiting    <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
      rsp_rdata  <= '0;
      mem_req    <= 1'b0;
      mem_write  <= 1'b0;
      mem_wdata  <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
      if (waiting) begin
        if (mem_ack) begin
          waiting    <= 1'b0;
          mem_req    <= 1'b0;
          rsp_valid  <= 1'b1;
          rsp_status <= O_MEM;
          rsp_rdata  <= mem_write ? '0 : mem_rdata;
        end
      end else if (accept) begin
        if (outc == O_MEM) begin
          waiting   <= 1'b1;
          mem_req   <= 1'b1;
          mem_write <= req_write;
          mem_wdata <= req_wdata;
        end else begin
          rsp_valid  <= 1'b1;
          rsp_status <= outc;
          rsp_rdata  <= '0;
          if (outc == O_REG1) begin
            if (req_write) reg1 <= new1;
            else           rsp_rdata <= reg1;
          end
          if (outc == O_REG2) begin
            if (req_write) reg2 <= new2;
            else           rsp_rdata <= reg2;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sysreg_aux_router_chk.sv
module sysreg_aux_router_chk #(
  parameter int DW  = 64,
  parameter int AW  = 12,
  parameter int ECW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           req_write,
  input logic [1:0]     req_op0,
  input logic [2:0]     req_op1,
  input logic [3:0]     req_crn,
  input logic [3:0]     req_crm,
  input logic [2:0]     req_op2,
  input logic [1:0]     req_el,
  input logic           el2_en,
  input logic           trap_aux,
  input logic           rsp_valid,
  input logic [4:0]     rsp_status,
  input logic [ECW-1:0] rsp_ec,
  input logic           mem_req,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_wdata,
  input logic           mem_ack
);
  wire take    = req_valid && req_ready;
  wire prim_en = req_op0 == 2'd3 && req_crn == 4'd1 && req_op1 == 3'd0 &&
                 req_crm == 4'd0 && req_op2 == 3'd1;

  // R3
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(rsp_status) == 1);
  // R3
  trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status[1]) |-> rsp_ec == 6'h18);
  // R2
  level0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_el == 2'd0) |=> (rsp_valid && rsp_status[0]));
  // R4
  aux_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_el == 2'd1 && el2_en && trap_aux && prim_en) |=> (rsp_valid && rsp_status[1]));
  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_wdata)));
  // R12
  mem_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (rsp_valid && rsp_status[4] && !mem_req));
  // R12
  mem_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr == 12'h118);
  // R12
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
endmodule

bind sysreg_aux_router sysreg_aux_router_chk #(.DW(DW), .AW(AW), .ECW(ECW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn),
  .req_crm(req_crm), .req_op2(req_op2), .req_el(req_el), .el2_en(el2_en),
  .trap_aux(trap_aux), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .rsp_ec(rsp_ec), .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack)
);

// File: tb/sysreg_aux_router_bench.sv
module sysreg_aux_router_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_op0 = 0, req_el = 0;
  logic [2:0]  req_op1 = 0, req_op2 = 0, nv = 0;
  logic [3:0]  req_crn = 0, req_crm = 0;
  logic [63:0] req_wdata = 0;
  logic        el2_en = 0, trap_aux = 0, host_mode = 0, el3_present = 0;
  logic        fgt_el3_en = 1, fgt_rd_en = 1, fgt_wr_en = 1;
  logic [63:0] mk [2];
  logic        ack [2];
  logic [63:0] mrd [2];

  logic        rdy [2], rv [2], mreq [2], mwr [2];
  logic [4:0]  st [2];
  logic [5:0]  ec [2];
  logic [63:0] rd [2], mwd [2];
  logic [11:0] mad [2];

  sysreg_aux_router u_sysreg_aux_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]),
    .req_write(req_write), .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn),
    .req_crm(req_crm), .req_op2(req_op2), .req_el(req_el), .req_wdata(req_wdata),
    .el2_en(el2_en), .trap_aux(trap_aux), .host_mode(host_mode), .nv(nv),
    .el3_present(el3_present), .fgt_el3_en(fgt_el3_en), .fgt_rd_en(fgt_rd_en),
    .fgt_wr_en(fgt_wr_en), .mask_l1(mk[0]), .mask_l2(mk[1]),
    .rsp_valid(rv[0]), .rsp_status(st[0]), .rsp_ec(ec[0]), .rsp_rdata(rd[0]),
    .mem_req(mreq[0]), .mem_write(mwr[0]), .mem_addr(mad[0]), .mem_wdata(mwd[0]),
    .mem_ack(ack[0]), .mem_rdata(mrd[0]));

  sysreg_aux_router #(.ALT_ACCESSOR(1'b0), .MASK_FEATURE(1'b0), .FINE_TRAP(1'b0)) u_bare (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]),
    .req_write(req_write), .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn),
    .req_crm(req_crm), .req_op2(req_op2), .req_el(req_el), .req_wdata(req_wdata),
    .el2_en(el2_en), .trap_aux(trap_aux), .host_mode(host_mode), .nv(nv),
    .el3_present(el3_present), .fgt_el3_en(fgt_el3_en), .fgt_rd_en(fgt_rd_en),
    .fgt_wr_en(fgt_wr_en), .mask_l1(mk[0]), .mask_l2(mk[1]),
    .rsp_valid(rv[1]), .rsp_status(st[1]), .rsp_ec(ec[1]), .rsp_rdata(rd[1]),
    .mem_req(mreq[1]), .mem_write(mwr[1]), .mem_addr(mad[1]), .mem_wdata(mwd[1]),
    .mem_ack(ack[1]), .mem_rdata(mrd[1]));

  int checks = 0, fails = 0;
  logic [63:0] mdl [2][2];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 undefined, 1 trap, 2 level-1 copy, 3 level-2 copy, 4 memory
  function automatic int exp_out(bit alt, bit fgt, bit mf, int el, int enc, bit wr,
                                 logic [2:0] v, bit e2, bit tr, bit ho, bit e3,
                                 bit f3, bit fr, bit fw);
    bit ok = (enc == 0) || (enc == 1 && alt) || (enc == 2 && mf);
    if (el == 0 || !ok) return 0;
    if (enc == 1) begin
      if (el == 1) begin
        if (v == 3'b101) return 4;
        if (v[0]) return 1;
        return 0;
      end
      return ho ? 2 : 0;
    end
    if (el == 1) begin
      if (e2 && tr) return 1;
      if (enc == 2 && fgt && e2 && ((e3 && !f3) || (wr ? !fw : !fr))) return 1;
      if (v[2] && v[0] && (!alt || v == 3'b111)) return 4;
      return 2;
    end
    if (el == 2) return (alt && ho) ? 3 : 2;
    return 2;
  endfunction

  function automatic string tag_of(int ex, int enc, int el);
    if (enc == 3 || el == 0) return "R2";
    if (enc == 1) return (el == 1) ? "R7" : "R8";
    if (el == 1 && ex == 1) return (enc == 2) ? "R4 R5" : "R4";
    if (ex == 4) return "R6";
    if (el == 1) return "R6";
    return "R9";
  endfunction

  task automatic access(input int el, input int enc, input bit wr, input logic [2:0] v,
                        input bit e2, input bit tr, input bit ho, input bit e3,
                        input bit f3, input bit fr, input bit fw, input logic [63:0] wd);
    int ex [2];
    logic [63:0] exd [2];
    bit got [2];
    bit acked [2];
    for (int i = 0; i < 2; i++) begin
      ex[i] = exp_out(i == 0, i == 0, i == 0, el, enc, wr, v, e2, tr, ho, e3, f3, fr, fw);
      exd[i] = 64'd0;
      if (!wr && (ex[i] == 2 || ex[i] == 3)) exd[i] = mdl[i][ex[i]-2];
      if (!wr && ex[i] == 4) exd[i] = mrd[i];
      got[i] = 0;
      acked[i] = 0;
    end
    @(negedge clk);
    req_el = el[1:0]; req_write = wr; req_wdata = wd; nv = v;
    el2_en = e2; trap_aux = tr; host_mode = ho; el3_present = e3;
    fgt_el3_en = f3; fgt_rd_en = fr; fgt_wr_en = fw;
    req_op0 = 2'd3; req_crn = 4'd1;
    case (enc)
      0: begin req_op1 = 3'd0; req_crm = 4'd0; req_op2 = 3'd1; end
      1: begin req_op1 = 3'd5; req_crm = 4'd0; req_op2 = 3'd1; end
      2: begin req_op1 = 3'd0; req_crm = 4'd4; req_op2 = 3'd5; end
      default: begin req_op1 = 3'd0; req_crm = 4'd0; req_op2 = 3'd2; end
    endcase
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    for (int c = 0; c < 8 && !(got[0] && got[1]); c++) begin
      for (int i = 0; i < 2; i++) begin
        if (!got[i] && rv[i]) begin
          got[i] = 1;
          // R3: one-hot status and trap class
          chk(st[i] == (5'b1 << ex[i]), tag_of(ex[i], enc, el), {59'd0, st[i]}, 64'd1 << ex[i]);
          chk(ec[i] == ((ex[i] == 1) ? 6'h18 : 6'h0), "R3", {58'd0, ec[i]}, (ex[i] == 1) ? 64'h18 : 64'h0);
          // R10 R11: read data from the model of both copies
          chk(rd[i] == exd[i], (ex[i] == 4) ? "R12" : "R10 R11", rd[i], exd[i]);
          if (wr && (ex[i] == 2 || ex[i] == 3)) begin
            logic [63:0] m = mk[ex[i]-2];
            logic [63:0] o = mdl[i][ex[i]-2];
            if (i == 0 && (el == 1 || ex[i] == 3))
              mdl[i][ex[i]-2] = (wd & ~m) | (o & m);
            else
              mdl[i][ex[i]-2] = wd;
          end
        end
      end
      for (int i = 0; i < 2; i++) begin
        if (mreq[i] && !ack[i]) begin
          // R12: memory request fields
          chk(!acked[i] && ex[i] == 4, "R12", {63'd0, mreq[i]}, {63'd0, ex[i] == 4});
          chk(mad[i] == 12'h118 && mwr[i] == wr && mwd[i] == wd, "R12", mwd[i], wd);
          ack[i] = 1;
          acked[i] = 1;
        end else begin
          ack[i] = 0;
        end
      end
      if (!(got[0] && got[1])) @(negedge clk);
    end
    for (int i = 0; i < 2; i++) begin
      chk(got[i], "R3 R12", {63'd0, got[i]}, 64'd1);
      ack[i] = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n = 0;
    mk[0] = 64'h00FF_00FF_F0F0_0001;
    mk[1] = 64'hFFFF_0000_0000_FFFF;
    mrd[0] = 64'h0118_CAFE_0000_0001;
    mrd[1] = 64'h0118_BEEF_0000_0002;
    ack[0] = 0; ack[1] = 0;
    for (int i = 0; i < 2; i++) begin mdl[i][0] = 0; mdl[i][1] = 0; end
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      // R1: reset state at the ports
      chk(rdy[i] && !rv[i] && !mreq[i], "R1", {61'd0, rdy[i], rv[i], mreq[i]}, 64'h4);
    end
    rst_n = 1;
    // R1: both copies read zero after reset
    access(3, 0, 0, 3'b000, 0, 0, 0, 0, 1, 1, 1, 64'd0);
    access(2, 0, 0, 3'b000, 1, 0, 1, 0, 1, 1, 1, 64'd0);
    for (int el = 0; el < 4; el++)
      for (int enc = 0; enc < 4; enc++)
        for (int v = 0; v < 8; v++)
          for (int ctl = 0; ctl < 8; ctl++)
            for (int wr = 1; wr >= 0; wr--) begin
              int nf = (el == 1 && enc == 2) ? 16 : 1;
              for (int f = 0; f < nf; f++) begin
                logic [63:0] wd;
                bit e3 = (nf == 16) ? f[3] : 1'b1;
                bit f3 = (nf == 16) ? f[2] : 1'b1;
                bit fr = (nf == 16) ? f[1] : 1'b1;
                bit fw = (nf == 16) ? f[0] : 1'b1;
                n++;
                wd = {32'(n) * 32'h9E37_79B9, ~(32'(n) * 32'h85EB_CA6B)};
                access(el, enc, wr[0], v[2:0], ctl[0], ctl[1], ctl[2], e3, f3, fr, fw, wd);
              end
            end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule